// File: doc/BRIEF.md
# Shared-Bus Request Issue Controller

This block lives inside one symmetric agent on a processor bus shared by several agents. Each clock it decides whether the agent may put the head of its local pending queue onto the bus. It weighs symmetric ownership, the priority agent's request line, the wire-OR stall line and the agent's own locked sequence. It also drives the agent's share of the stall line from the fill level of an in-order queue (IOQ) counter. That counter is kept apart from arbitration.

All bus-side lines are active-low. The stall line works on a two-clock rhythm. Its driven value changes only on drive slots, and the agent looks at the line, and may issue, only on the sample slot that follows. A bus-initialization line, when observation is strapped on, resets only the lock and arbitration state. After it the agent must win the bus again before it can finish its pending entries. The IOQ count is not touched.

Top module: `bus_issue_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `issue_o` becomes 0, `stall_n_o` becomes 1 and `ioq_level` becomes 0.
- R2: An edge at which `prio_req_n` is 0 produces no issue, unless a locked sequence is already in progress (a locked request was issued earlier and `lock_n` has stayed 0 since).
- R3: While a locked sequence is in progress, `prio_req_n` = 0 does not stop further issues of that sequence.
- R4: A slot phase toggles every clock and starts as a sample slot on the first edge after reset. Issue decisions happen only at sample-slot edges, so `issue_o` is never high in two consecutive cycles. A sample edge that sees `stall_in_n` = 0 produces no issue.
- R5: `stall_n_o` changes only after drive-slot edges. There it takes the value 0 if `ioq_level` is 7 or more, and 1 otherwise.
- R6: With observation strapped on, `binit_n` = 0 at an edge suppresses the issue of that edge, ends any locked sequence and returns arbitration to idle. Issuing resumes only after arbitration is won again, which takes a request cycle followed by an edge with `arb_win` = 1.
- R7: Bus initialization leaves `ioq_level` unchanged.
- R8: With observation strapped off, `binit_n` has no effect on any output.
- R9: The observation strap `cfg_binit_obs` is captured only while `rst` is high. Later changes are ignored.
- R10: `ioq_level` rises by 1 in the cycle after `issue_o` is high and falls by 1 in the cycle after `ioq_done` is high (ignored at 0). It never exceeds 8, and no issue is made while it is 8.
- R11: Arbitration goes idle to requesting when `pend_valid` is 1, then to owning on an edge with `arb_win` = 1. It returns to idle when nothing is pending and no lock is held. An issue requires ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset; straps captured while high |
| cfg_binit_obs | input | 1 | Strap: 1 enables observation of bus initialization |
| prio_req_n | input | 1 | Priority agent request line, active-low |
| stall_in_n | input | 1 | Wire-OR stall line as seen on the bus, active-low |
| binit_n | input | 1 | Bus initialization line, active-low |
| lock_n | input | 1 | Local locked-sequence indication, active-low |
| arb_win | input | 1 | Symmetric arbitration won this cycle |
| pend_valid | input | 1 | Local pending queue holds a request |
| ioq_done | input | 1 | One in-order queue entry completed |
| issue_o | output | 1 | Registered strobe: head request issued |
| stall_n_o | output | 1 | This agent's stall request, active-low |
| ioq_level | output | 4 | Outstanding in-order queue entries |

## Verification
The checker checks four things on every cycle: the one-in-two issue spacing, the priority block with its locked-sequence exception, the IOQ bound with its full-queue block, and the rule that the stall output moves only after drive slots. It also checks that bus initialization clears arbitration and lock, and that every issue comes from an owning state. The bench's scenarios are needed for the rest. They show that re-arbitration really comes before issuing resumes after initialization, and that the IOQ count survives initialization. They also show that a strap changed after reset is ignored, and that the exact cycle in which the stall output reaches the threshold is right. A cycle model compares all three outputs on every clock under random traffic.

// File: rtl/bic_pkg.sv
package bic_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_REQ  = 2'd1,
    ARB_OWN  = 2'd2
  } arb_st_t;
endpackage

// File: rtl/bic_arb.sv
module bic_arb
  import bic_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    pend_valid,
  input  logic    arb_win,
  input  logic    lock_held,
  input  logic    binit_hit,
  output arb_st_t st
);
  arb_st_t st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ARB_IDLE: if (pend_valid) st_nx = ARB_REQ;
      ARB_REQ:  if (arb_win)    st_nx = ARB_OWN;
      ARB_OWN:  if (!pend_valid && !lock_held) st_nx = ARB_IDLE;
      default:  st_nx = ARB_IDLE;
    endcase
    if (binit_hit) st_nx = ARB_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ARB_IDLE;
    else     st <= st_nx;
  end
endmodule

// File: rtl/bic_ioq.sv
module bic_ioq #(
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             done,
  output logic [LVL_W-1:0] level
);
  logic dec;
  assign dec = done && (level != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/bic_stall.sv
module bic_stall #(
  parameter int DEPTH    = 8,
  parameter int STALL_AT = 7,
  parameter int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  output logic             drv_slot,
  output logic             stall_n
);
  localparam logic [LVL_W-1:0] THRESH = LVL_W'(STALL_AT);

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_slot <= 1'b0;
      stall_n  <= 1'b1;
    end else begin
      drv_slot <= ~drv_slot;
      if (drv_slot) stall_n <= !(level >= THRESH);
    end
  end
endmodule

// File: rtl/bus_issue_ctrl.sv
module bus_issue_ctrl
  import bic_pkg::*;
#(
  parameter int IOQ_DEPTH = 8,
  parameter int STALL_AT  = 7,
  parameter int LVL_W     = $clog2(IOQ_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_binit_obs,
  input  logic             prio_req_n,
  input  logic             stall_in_n,
  input  logic             binit_n,
  input  logic             lock_n,
  input  logic             arb_win,
  input  logic             pend_valid,
  input  logic             ioq_done,
  output logic             issue_o,
  output logic             stall_n_o,
  output logic [LVL_W-1:0] ioq_level
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(IOQ_DEPTH);

  logic    obs_en;
  logic    lock_held;
  logic    drv_slot;
  logic    binit_hit;
  logic    lock_cont;
  logic    can_issue;
  arb_st_t arb_st;

  // strap capture: only while reset is held
  always_ff @(posedge clk) begin
    if (rst) obs_en <= cfg_binit_obs;
  end

  assign binit_hit = obs_en && !binit_n;
  assign lock_cont = lock_held && !lock_n;

  assign can_issue = !drv_slot && !binit_hit && (arb_st == ARB_OWN) &&
                     pend_valid && stall_in_n &&
                     (prio_req_n || lock_cont) && (ioq_level < FULL_LVL);

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_o   <= 1'b0;
      lock_held <= 1'b0;
    end else begin
      issue_o <= can_issue;
      if (binit_hit || lock_n) lock_held <= 1'b0;
      else if (can_issue)      lock_held <= 1'b1;
    end
  end

  bic_arb u_arb (
    .clk        (clk),
    .rst        (rst),
    .pend_valid (pend_valid),
    .arb_win    (arb_win),
    .lock_held  (lock_held),
    .binit_hit  (binit_hit),
    .st         (arb_st)
  );

  bic_ioq #(.DEPTH(IOQ_DEPTH), .LVL_W(LVL_W)) u_ioq (
    .clk   (clk),
    .rst   (rst),
    .inc   (issue_o),
    .done  (ioq_done),
    .level (ioq_level)
  );

  bic_stall #(.DEPTH(IOQ_DEPTH), .STALL_AT(STALL_AT), .LVL_W(LVL_W)) u_stall (
    .clk      (clk),
    .rst      (rst),
    .level    (ioq_level),
    .drv_slot (drv_slot),
    .stall_n  (stall_n_o)
  );
endmodule

// File: rtl/bic_chk.sv
module bic_chk
  import bic_pkg::*;
#(
  parameter int IOQ_DEPTH = 8,
  parameter int LVL_W     = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             issue_o,
  input logic             stall_n_o,
  input logic [LVL_W-1:0] ioq_level,
  input logic             prio_req_n,
  input logic             lock_n,
  input logic             lock_held,
  input logic             drv_slot,
  input logic             binit_hit,
  input arb_st_t          arb_st
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(IOQ_DEPTH);

  AST_ISSUE_SPACED: assert property (@(posedge clk) disable iff (rst)
    issue_o |=> !issue_o); // R4

  AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (issue_o && !$past(prio_req_n)) |-> ($past(lock_held) && !$past(lock_n))); // R2

  AST_IOQ_BOUND: assert property (@(posedge clk) disable iff (rst)
    ioq_level <= FULL_LVL); // R10

  AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (ioq_level == FULL_LVL) |=> !issue_o); // R10

  AST_STALL_SLOT: assert property (@(posedge clk) disable iff (rst)
    !$stable(stall_n_o) |-> $past(drv_slot)); // R5

  AST_BINIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    binit_hit |=> (arb_st == ARB_IDLE && !lock_held)); // R6

  AST_OWN_ONLY: assert property (@(posedge clk) disable iff (rst)
    issue_o |-> ($past(arb_st) == ARB_OWN)); // R11
endmodule

bind bus_issue_ctrl bic_chk #(.IOQ_DEPTH(IOQ_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .issue_o    (issue_o),
  .stall_n_o  (stall_n_o),
  .ioq_level  (ioq_level),
  .prio_req_n (prio_req_n),
  .lock_n     (lock_n),
  .lock_held  (lock_held),
  .drv_slot   (drv_slot),
  .binit_hit  (binit_hit),
  .arb_st     (arb_st)
);

// File: tb/tb_bus_issue_ctrl.sv
`timescale 1ns/1ps
module tb_bus_issue_ctrl;
  localparam int DEPTH = 8;
  localparam int THR   = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_binit_obs = 1'b1;
  logic prio_req_n = 1'b1, stall_in_n = 1'b1, binit_n = 1'b1, lock_n = 1'b1;
  logic arb_win = 1'b0, pend_valid = 1'b0, ioq_done = 1'b0;
  logic issue_o, stall_n_o;
  logic [3:0] ioq_level;

  int checks = 0, failures = 0, pend_cnt = 0, issue_total = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  bus_issue_ctrl dut (
    .clk(clk), .rst(rst), .cfg_binit_obs(cfg_binit_obs),
    .prio_req_n(prio_req_n), .stall_in_n(stall_in_n), .binit_n(binit_n),
    .lock_n(lock_n), .arb_win(arb_win), .pend_valid(pend_valid),
    .ioq_done(ioq_done), .issue_o(issue_o), .stall_n_o(stall_n_o),
    .ioq_level(ioq_level)
  );

  // ---------- cycle model built from the requirements ----------
  int m_arb = 0;       // 0 idle, 1 requesting, 2 owning
  bit m_ph = 0, m_lock = 0, m_iss = 0, m_stall_n = 1, m_obs = 1;
  int m_lvl = 0;

  function automatic bit model_can(bit hit);
    return !m_ph && !hit && (m_arb == 2) && pend_valid && stall_in_n &&
           (prio_req_n || (m_lock && !lock_n)) && (m_lvl < DEPTH);
  endfunction

  function automatic int arb_next(bit hit);
    if (hit) return 0;
    case (m_arb)
      0: return pend_valid ? 1 : 0;
      1: return arb_win ? 2 : 1;
      default: return (!pend_valid && !m_lock) ? 0 : 2;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_arb = 0; m_ph = 0; m_lock = 0; m_iss = 0; m_stall_n = 1; m_lvl = 0;
      m_obs = cfg_binit_obs;
    end else begin
      bit hit, can; int nlvl, narb; bit nlock;
      hit  = m_obs && !binit_n;
      can  = model_can(hit);
      narb = arb_next(hit);
      nlock = (hit || lock_n) ? 1'b0 : (m_lock || can);
      nlvl = m_lvl + (m_iss ? 1 : 0) - ((ioq_done && m_lvl != 0) ? 1 : 0);
      if (m_ph) m_stall_n = !(m_lvl >= THR);
      m_ph = !m_ph; m_iss = can; m_lvl = nlvl; m_arb = narb; m_lock = nlock;
    end
  end

  task automatic expect_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (!rst) begin
      expect_eq(cur_tag, "issue_o", issue_o, m_iss);
      expect_eq("R5", "stall_n_o", stall_n_o, m_stall_n);
      expect_eq("R10", "ioq_level", ioq_level, m_lvl);
    end
    if (issue_o && pend_cnt > 0) pend_cnt--;
    if (issue_o) issue_total++;
    pend_valid = (pend_cnt != 0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_reset(bit obs);
    rst = 1'b1; cfg_binit_obs = obs;
    prio_req_n = 1; stall_in_n = 1; binit_n = 1; lock_n = 1;
    arb_win = 0; ioq_done = 0; pend_cnt = 0; pend_valid = 0;
    ticks(3);
    rst = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed, base;
    seed = 32'h5eed_1234;
    void'($urandom(seed));

    // R1 reset state
    do_reset(1'b1);
    tick();
    expect_eq("R1", "issue after reset", issue_o, 0);
    expect_eq("R1", "stall after reset", stall_n_o, 1);
    expect_eq("R1", "level after reset", ioq_level, 0);

    // R11 no ownership without arb_win
    cur_tag = "R11";
    pend_cnt = 3; pend_valid = 1;
    base = issue_total;
    ticks(8);
    expect_eq("R11", "issues without win", issue_total - base, 0);
    arb_win = 1;
    ticks(4);
    expect_eq("R11", "issues once owned", (issue_total - base) > 0, 1);

    // R4 stall line blocks and spacing
    cur_tag = "R4";
    ioq_done = 1; pend_cnt = 20; stall_in_n = 0;
    base = issue_total;
    ticks(8);
    expect_eq("R4", "issues under stall", issue_total - base, 0);
    stall_in_n = 1;
    base = issue_total;
    ticks(10);
    expect_eq("R4", "issues in 10 clocks", issue_total - base, 5);

    // R2 priority request blocks
    cur_tag = "R2";
    prio_req_n = 0;
    base = issue_total;
    ticks(8);
    expect_eq("R2", "issues under priority", issue_total - base, 0);
    prio_req_n = 1;

    // R3 locked sequence continues under priority
    cur_tag = "R3";
    lock_n = 0;
    ticks(3);
    prio_req_n = 0;
    base = issue_total;
    ticks(8);
    expect_eq("R3", "locked issues under priority", (issue_total - base) >= 3, 1);
    lock_n = 1; prio_req_n = 1;

    // R10 / R5 fill the queue
    cur_tag = "R10";
    ioq_done = 0; pend_cnt = 20;
    ticks(30);
    expect_eq("R10", "level at full", ioq_level, DEPTH);
    expect_eq("R5", "stall asserted at full", stall_n_o, 0);
    base = issue_total;
    ticks(6);
    expect_eq("R10", "issues while full", issue_total - base, 0);

    // R6 / R7 bus initialization with observation on
    cur_tag = "R6";
    binit_n = 0; tick(); binit_n = 1;
    expect_eq("R7", "level kept over init", ioq_level, DEPTH);
    arb_win = 0; ioq_done = 1; tick(); ioq_done = 0;
    base = issue_total;
    ticks(8);
    expect_eq("R6", "issues before re-arbitration", issue_total - base, 0);
    arb_win = 1;
    ticks(6);
    expect_eq("R6", "issues after re-arbitration", (issue_total - base) > 0, 1);

    // R8 / R9 observation strapped off, strap flipped after reset
    do_reset(1'b0);
    cfg_binit_obs = 1;
    cur_tag = "R8";
    arb_win = 1; ioq_done = 1; pend_cnt = 10; pend_valid = 1;
    ticks(4);
    binit_n = 0;
    base = issue_total;
    ticks(8);
    expect_eq("R8", "issues while init line low", (issue_total - base) >= 3, 1);
    expect_eq("R9", "late strap ignored", (issue_total - base) >= 3, 1);
    binit_n = 1;

    // constrained random traffic
    do_reset(1'b1);
    cur_tag = "R2";
    for (int c = 0; c < 6000; c++) begin
      prio_req_n = ($urandom_range(0, 3) != 0);
      stall_in_n = ($urandom_range(0, 3) != 0);
      binit_n    = ($urandom_range(0, 40) != 0);
      arb_win    = ($urandom_range(0, 3) != 0);
      ioq_done   = ($urandom_range(0, 2) == 0);
      if (c % 16 == 0) lock_n = ($urandom_range(0, 2) != 0);
      if ($urandom_range(0, 2) == 0 && pend_cnt < 12) pend_cnt++;
      pend_valid = (pend_cnt != 0);
      if (c == 3000) do_reset(1'b0);
      tick();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule